// File: doc/BRIEF.md
# Measurement Readback Status Capture

This block builds the three bytes a host reads back through a serial control interface: a status byte and two measurement bytes. The status byte carries the stereo pilot indication, a flag that shows a seek step is running, the measurement source flag, and a sticky flag that records a power-on reset. A fixed identification field of zero completes the byte.

The measurement bytes carry an 8-bit level reading, a 4-bit ultrasonic-noise reading and a 4-bit wideband-AM reading. By default they follow the main channel's live values. An alternate-frequency update switches them to the alternative channel's live values. When the update ends, the alternate values present at that clock edge are frozen. They stay frozen until the host completes a read, and then the readings go back to the live main channel. A completed read also clears the sticky reset flag.

Top module: `status_readback`

## Requirements
- R1: Status byte fields: bit 7 = pilot input, bit 6 = seek-busy input (both combinational), bit 5 = source flag (1 = alternate data), bit 4 = reset flag, bit 3 reserved and always 0, bits 2..0 identification fixed at 000.
- R2: After `rst_n` is released, the reset flag (bit 4) reads 1 and the source flag (bit 5) reads 0.
- R3: A `por_pulse` sets bit 4 from the cycle after the clock edge at which it is seen.
- R4: A `rd_done` clears bit 4 from the cycle after the clock edge at which it is seen.
- R5: If `por_pulse` and `rd_done` are seen at the same edge, bit 4 stays 1.
- R6: While bit 5 is 0, `lvl_byte` equals `live_lvl` and `noise_byte` equals `{live_usn, live_wam}` in the same cycle, with the noise reading in bits 7..4 and the wideband-AM reading in bits 3..0.
- R7: After the edge at which `upd_start` is seen, bit 5 reads 1 and the measurement bytes follow `alt_lvl` and `{alt_usn, alt_wam}` continuously. A `rd_done` during tracking leaves bit 5 at 1.
- R8: At the edge where `upd_end` is seen during tracking, the alternate values present at that edge are captured. From then on the bytes show the captured values, whatever the inputs do, and bit 5 stays 1.
- R9: A `rd_done` while holding returns bit 5 to 0 and the bytes to live main data from the next cycle.
- R10: An `upd_start` while holding restarts continuous tracking of the alternate inputs. If `upd_start` and `upd_end` are seen at the same edge, `upd_start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| por_pulse | input | 1 | Power-on reset detected |
| pilot | input | 1 | Stereo pilot present |
| seek_busy | input | 1 | Seek step in progress |
| upd_start | input | 1 | Alternate-frequency update begins |
| upd_end | input | 1 | Alternate-frequency update ends |
| rd_done | input | 1 | Host finished reading the status |
| live_lvl | input | LVL_W | Main channel level |
| live_usn | input | NIB_W | Main channel ultrasonic noise |
| live_wam | input | NIB_W | Main channel wideband AM |
| alt_lvl | input | LVL_W | Alternate channel level |
| alt_usn | input | NIB_W | Alternate channel ultrasonic noise |
| alt_wam | input | NIB_W | Alternate channel wideband AM |
| stat_byte | output | 8 | Status byte |
| lvl_byte | output | LVL_W | Level byte |
| noise_byte | output | 2*NIB_W | Noise / wideband-AM byte |

## Verification
Main and alternate inputs always carry different values. This lets each check show which source feeds the output bytes. During tracking, the alternate inputs change every cycle to confirm that the bytes follow them continuously. After the update ends, both input sets change again, which separates a true capture from a pass-through. For the reset flag, the bench tries a read alone, a detect alone, and both at once, which tells apart the clear, the set and the event-preserving priority.

// File: rtl/status_readback.sv
module status_readback #(
  parameter int LVL_W = 8,
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_pulse,
  input  logic               pilot,
  input  logic               seek_busy,
  input  logic               upd_start,
  input  logic               upd_end,
  input  logic               rd_done,
  input  logic [LVL_W-1:0]   live_lvl,
  input  logic [NIB_W-1:0]   live_usn,
  input  logic [NIB_W-1:0]   live_wam,
  input  logic [LVL_W-1:0]   alt_lvl,
  input  logic [NIB_W-1:0]   alt_usn,
  input  logic [NIB_W-1:0]   alt_wam,
  output logic [7:0]         stat_byte,
  output logic [LVL_W-1:0]   lvl_byte,
  output logic [2*NIB_W-1:0] noise_byte
);

  localparam int MW = 2 * NIB_W;

  typedef enum logic [1:0] {SRC_MAIN, SRC_TRACK, SRC_HOLD} src_t;

  src_t             src_q;
  logic             por_q;
  logic [LVL_W-1:0] hold_lvl;
  logic [MW-1:0]    hold_nse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= SRC_MAIN;
      por_q <= 1'b1;
    end else begin
      if (por_pulse)    por_q <= 1'b1;
      else if (rd_done) por_q <= 1'b0;
      if (upd_start)
        src_q <= SRC_TRACK;
      else if (src_q == SRC_TRACK && upd_end)
        src_q <= SRC_HOLD;
      else if (src_q == SRC_HOLD && rd_done)
        src_q <= SRC_MAIN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_lvl <= '0;
      hold_nse <= '0;
    end else if (src_q == SRC_TRACK && upd_end && !upd_start) begin
      hold_lvl <= alt_lvl;
      hold_nse <= {alt_usn, alt_wam};
    end
  end

  wire use_alt = (src_q != SRC_MAIN);

  assign stat_byte = {pilot, seek_busy, use_alt, por_q, 4'b0000};

  always_comb begin
    case (src_q)
      SRC_TRACK: begin
        lvl_byte   = alt_lvl;
        noise_byte = {alt_usn, alt_wam};
      end
      SRC_HOLD: begin
        lvl_byte   = hold_lvl;
        noise_byte = hold_nse;
      end
      default: begin
        lvl_byte   = live_lvl;
        noise_byte = {live_usn, live_wam};
      end
    endcase
  end

  a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[3:0] == 4'b0000);

  a_r3_por_sets: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> stat_byte[4]);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !por_pulse) |=> !stat_byte[4]);

  a_r6_main_live: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_byte[5] |-> (lvl_byte == live_lvl && noise_byte == {live_usn, live_wam}));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_HOLD && !upd_start && !rd_done) |=> ($stable(lvl_byte) && $stable(noise_byte)));

  a_r9_read_reverts: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_HOLD && rd_done && !upd_start) |=> !stat_byte[5]);

endmodule

// File: tb/sim_status_readback.sv
module sim_status_readback;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_pulse = 0, pilot = 0, seek_busy = 0, upd_start = 0, upd_end = 0, rd_done = 0;
  logic [7:0] live_lvl = 0, alt_lvl = 0;
  logic [3:0] live_usn = 0, live_wam = 0, alt_usn = 0, alt_wam = 0;
  logic [7:0] stat_byte, lvl_byte, noise_byte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  status_readback u0 (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .pilot(pilot),
    .seek_busy(seek_busy), .upd_start(upd_start), .upd_end(upd_end),
    .rd_done(rd_done), .live_lvl(live_lvl), .live_usn(live_usn),
    .live_wam(live_wam), .alt_lvl(alt_lvl), .alt_usn(alt_usn),
    .alt_wam(alt_wam), .stat_byte(stat_byte), .lvl_byte(lvl_byte),
    .noise_byte(noise_byte)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_live(input logic [7:0] l, input logic [3:0] u, input logic [3:0] w);
    live_lvl = l; live_usn = u; live_wam = w;
  endtask

  task automatic set_alt(input logic [7:0] l, input logic [3:0] u, input logic [3:0] w);
    alt_lvl = l; alt_usn = u; alt_wam = w;
  endtask

  task automatic t_reset();
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R2 por flag after reset", {7'b0, stat_byte[4]}, 8'h01);
    chk("R2 source after reset", {7'b0, stat_byte[5]}, 8'h00);
  endtask

  task automatic t_layout();
    pilot = 1; seek_busy = 0; #1;
    chk("R1 pilot bit", {6'b0, stat_byte[7:6]}, 8'h02);
    pilot = 0; seek_busy = 1; #1;
    chk("R1 seek bit", {6'b0, stat_byte[7:6]}, 8'h01);
    chk("R1 reserved and id", {4'b0, stat_byte[3:0]}, 8'h00);
    seek_busy = 0;
    step();
  endtask

  task automatic t_por();
    rd_done = 1; step(); rd_done = 0;
    chk("R4 read clears", {7'b0, stat_byte[4]}, 8'h00);
    step();
    chk("R4 stays clear", {7'b0, stat_byte[4]}, 8'h00);
    por_pulse = 1; step(); por_pulse = 0;
    chk("R3 detect sets", {7'b0, stat_byte[4]}, 8'h01);
    rd_done = 1; por_pulse = 1; step(); rd_done = 0; por_pulse = 0;
    chk("R5 coincident keeps", {7'b0, stat_byte[4]}, 8'h01);
    rd_done = 1; step(); rd_done = 0;
    chk("R4 clear after coincident", {7'b0, stat_byte[4]}, 8'h00);
  endtask

  task automatic t_live();
    set_alt(8'hEE, 4'hE, 4'hE);
    set_live(8'h00, 4'h0, 4'hF); #1;
    chk("R6 live level low", lvl_byte, 8'h00);
    chk("R6 live noise nibbles", noise_byte, 8'h0F);
    set_live(8'hFF, 4'hA, 4'h5); #1;
    chk("R6 live level high", lvl_byte, 8'hFF);
    chk("R6 live noise swap", noise_byte, 8'hA5);
    step();
  endtask

  task automatic t_track();
    set_live(8'h11, 4'h1, 4'h1);
    set_alt(8'h80, 4'h3, 4'hC);
    upd_start = 1; step(); upd_start = 0;
    chk("R7 source flag set", {7'b0, stat_byte[5]}, 8'h01);
    chk("R7 alt level", lvl_byte, 8'h80);
    chk("R7 alt noise", noise_byte, 8'h3C);
    set_alt(8'h81, 4'h4, 4'hD); #1;
    chk("R7 follows alt level", lvl_byte, 8'h81);
    chk("R7 follows alt noise", noise_byte, 8'h4D);
    rd_done = 1; step(); rd_done = 0;
    chk("R7 read during tracking keeps source", {7'b0, stat_byte[5]}, 8'h01);
    chk("R7 still tracking", lvl_byte, 8'h81);
  endtask

  task automatic t_hold();
    set_alt(8'h5A, 4'h6, 4'h9);
    upd_end = 1; step(); upd_end = 0;
    set_alt(8'hC3, 4'h2, 4'h7);
    set_live(8'h22, 4'h2, 4'h2);
    step();
    chk("R8 held level", lvl_byte, 8'h5A);
    chk("R8 held noise", noise_byte, 8'h69);
    chk("R8 source still alt", {7'b0, stat_byte[5]}, 8'h01);
    set_alt(8'h01, 4'h0, 4'h1); step();
    chk("R8 held after alt change", lvl_byte, 8'h5A);
  endtask

  task automatic t_revert();
    rd_done = 1; step(); rd_done = 0;
    chk("R9 source back to main", {7'b0, stat_byte[5]}, 8'h00);
    chk("R9 live level", lvl_byte, 8'h22);
    chk("R9 live noise", noise_byte, 8'h22);
  endtask

  task automatic t_restart();
    set_alt(8'h44, 4'h4, 4'h4);
    upd_start = 1; step(); upd_start = 0;
    upd_end = 1; step(); upd_end = 0;
    set_alt(8'h99, 4'h9, 4'h8);
    upd_start = 1; step(); upd_start = 0;
    chk("R10 restart tracks", lvl_byte, 8'h99);
    chk("R10 restart noise", noise_byte, 8'h98);
    upd_start = 1; upd_end = 1; step(); upd_start = 0; upd_end = 0;
    set_alt(8'h37, 4'h3, 4'h7); #1;
    chk("R10 start wins over end", lvl_byte, 8'h37);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_layout();
    t_por();
    t_live();
    t_track();
    t_hold();
    t_revert();
    t_restart();
    finish_run();
  end
endmodule